// File: doc/BRIEF.md
# Byte-Lane Bus Address Decoder

This block turns the upper address bits of a 24-bit, byte-addressed, 16-bit-wide processor bus into the active-low select strobes of the memories and peripherals on that bus. It looks at address bits 23 down to 17, the read/write line, the address strobe and the two data strobes. It is purely combinational. The strobes follow the bus within the same cycle, so they can gate memory chips directly.

Most memories sit on both halves of the data bus and get one strobe per byte lane. The upper-lane strobe is qualified by the upper data strobe and the lower-lane strobe by the lower data strobe. Read strobes and write strobes are produced separately. The video controller, palette memory and memory card expect word accesses only. Each of these gets a single strobe, which asserts when either data strobe is active. Read-only regions never produce a write strobe, and the holes in the map select nothing.

Top module: `bus_addr_decoder`

## Requirements
- R1: Byte addresses 0x000000–0x0FFFFF (bits 23..20 = 0000) are program ROM. On a read (rd_wr = 1), prom_oe_u_n and prom_oe_l_n assert low.
- R2: Byte addresses 0x100000–0x1FFFFF (0001) are work RAM. Reads assert wram_rd_u_n/wram_rd_l_n and writes (rd_wr = 0) assert wram_wr_u_n/wram_wr_l_n.
- R3: Byte addresses 0x200000–0x2FFFFF (0010) are the cartridge port. Reads assert cart_oe_u_n/cart_oe_l_n and writes assert cart_we_u_n/cart_we_l_n.
- R4: Byte addresses 0xC00000–0xCFFFFF (1100) are system ROM. srom_oe_u_n/srom_oe_l_n assert only when bits 23..20 equal 1100 and rd_wr is 1.
- R5: Byte addresses 0xD00000–0xDFFFFF (1101) are battery-backed RAM. Reads assert bram_oe_u_n/bram_oe_l_n and writes assert bram_we_u_n/bram_we_l_n.
- R6: Byte addresses 0x3C0000–0x3DFFFF (bits 23..17 = 0011110) are the video controller. A read asserts vid_rd_n and a write asserts vid_wr_n when either data strobe is low.
- R7: Byte addresses 0x400000–0x7FFFFF (bits 23..22 = 01) are palette RAM. pal_sel_n asserts on a read or a write when either data strobe is low.
- R8: Byte addresses 0x800000–0xBFFFFF (bits 23..22 = 10) are the memory card. card_sel_n asserts on any access with either data strobe low, card_rd_n asserts on reads and card_wr_n asserts on writes.
- R9: Every upper-lane (_u_) strobe follows uds_n and every lower-lane (_l_) strobe follows lds_n. A lane whose data strobe is high stays deasserted.
- R10: While as_n is high, every output is high, in the same cycle.
- R11: A write to program ROM or system ROM asserts no output at all.
- R12: Byte addresses 0x300000–0x3BFFFF, 0x3E0000–0x3FFFFF and 0xE00000–0xFFFFFF assert no output. At most one region is selected at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_hi | input | 7 | Address bits 23..17 |
| rd_wr | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| prom_oe_u_n | output | 1 | Program ROM read, upper lane |
| prom_oe_l_n | output | 1 | Program ROM read, lower lane |
| wram_rd_u_n | output | 1 | Work RAM read, upper lane |
| wram_rd_l_n | output | 1 | Work RAM read, lower lane |
| wram_wr_u_n | output | 1 | Work RAM write, upper lane |
| wram_wr_l_n | output | 1 | Work RAM write, lower lane |
| cart_oe_u_n | output | 1 | Cartridge port read, upper lane |
| cart_oe_l_n | output | 1 | Cartridge port read, lower lane |
| cart_we_u_n | output | 1 | Cartridge port write, upper lane |
| cart_we_l_n | output | 1 | Cartridge port write, lower lane |
| srom_oe_u_n | output | 1 | System ROM read, upper lane |
| srom_oe_l_n | output | 1 | System ROM read, lower lane |
| bram_oe_u_n | output | 1 | Battery RAM read, upper lane |
| bram_oe_l_n | output | 1 | Battery RAM read, lower lane |
| bram_we_u_n | output | 1 | Battery RAM write, upper lane |
| bram_we_l_n | output | 1 | Battery RAM write, lower lane |
| vid_rd_n | output | 1 | Video controller read, word |
| vid_wr_n | output | 1 | Video controller write, word |
| pal_sel_n | output | 1 | Palette RAM select, word |
| card_sel_n | output | 1 | Memory card select |
| card_rd_n | output | 1 | Memory card read |
| card_wr_n | output | 1 | Memory card write |

## Verification
The bench sweeps all 128 values of the address field, both directions, both address strobe levels and all four data strobe pairs. It compares every output against a map computed from byte-address ranges. The edges of the video window (0x3A/0x3B versus 0x3C, and 0x3D versus 0x3E) would catch a decoder that matched too few or too many address bits. Such a decoder would let the video strobes leak into the unmapped hole or drop half of the window. Writes to the two ROM regions would expose a decoder that ignores direction, since it would drive a ROM output onto the bus during a write. Single-lane accesses would catch swapped lanes, which show up as the wrong byte enable, and word strobes tied to only one data strobe, which show up as a missing select on odd-byte accesses.

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder (
  input  logic [6:0] addr_hi,
  input  logic       rd_wr,
  input  logic       as_n,
  input  logic       uds_n,
  input  logic       lds_n,
  output logic       prom_oe_u_n,
  output logic       prom_oe_l_n,
  output logic       wram_rd_u_n,
  output logic       wram_rd_l_n,
  output logic       wram_wr_u_n,
  output logic       wram_wr_l_n,
  output logic       cart_oe_u_n,
  output logic       cart_oe_l_n,
  output logic       cart_we_u_n,
  output logic       cart_we_l_n,
  output logic       srom_oe_u_n,
  output logic       srom_oe_l_n,
  output logic       bram_oe_u_n,
  output logic       bram_oe_l_n,
  output logic       bram_we_u_n,
  output logic       bram_we_l_n,
  output logic       vid_rd_n,
  output logic       vid_wr_n,
  output logic       pal_sel_n,
  output logic       card_sel_n,
  output logic       card_rd_n,
  output logic       card_wr_n
);

  logic lane_u, lane_l, lane_any, rd, wr;
  logic hit_prom, hit_wram, hit_cart, hit_srom, hit_bram, hit_vid, hit_pal, hit_card;

  assign lane_u   = !as_n && !uds_n;
  assign lane_l   = !as_n && !lds_n;
  assign lane_any = lane_u || lane_l;
  assign rd       = rd_wr;
  assign wr       = !rd_wr;

  assign hit_prom = addr_hi[6:3] == 4'b0000;
  assign hit_wram = addr_hi[6:3] == 4'b0001;
  assign hit_cart = addr_hi[6:3] == 4'b0010;
  assign hit_vid  = addr_hi      == 7'b0011110;
  assign hit_pal  = addr_hi[6:5] == 2'b01;
  assign hit_card = addr_hi[6:5] == 2'b10;
  assign hit_srom = addr_hi[6:3] == 4'b1100;
  assign hit_bram = addr_hi[6:3] == 4'b1101;

  assign prom_oe_u_n = !(hit_prom && rd && lane_u);
  assign prom_oe_l_n = !(hit_prom && rd && lane_l);

  assign wram_rd_u_n = !(hit_wram && rd && lane_u);
  assign wram_rd_l_n = !(hit_wram && rd && lane_l);
  assign wram_wr_u_n = !(hit_wram && wr && lane_u);
  assign wram_wr_l_n = !(hit_wram && wr && lane_l);

  assign cart_oe_u_n = !(hit_cart && rd && lane_u);
  assign cart_oe_l_n = !(hit_cart && rd && lane_l);
  assign cart_we_u_n = !(hit_cart && wr && lane_u);
  assign cart_we_l_n = !(hit_cart && wr && lane_l);

  assign srom_oe_u_n = !(hit_srom && rd && lane_u);
  assign srom_oe_l_n = !(hit_srom && rd && lane_l);

  assign bram_oe_u_n = !(hit_bram && rd && lane_u);
  assign bram_oe_l_n = !(hit_bram && rd && lane_l);
  assign bram_we_u_n = !(hit_bram && wr && lane_u);
  assign bram_we_l_n = !(hit_bram && wr && lane_l);

  assign vid_rd_n   = !(hit_vid && rd && lane_any);
  assign vid_wr_n   = !(hit_vid && wr && lane_any);
  assign pal_sel_n  = !(hit_pal && lane_any);
  assign card_sel_n = !(hit_card && lane_any);
  assign card_rd_n  = !(hit_card && rd && lane_any);
  assign card_wr_n  = !(hit_card && wr && lane_any);

endmodule

// File: rtl/bus_addr_decoder_chk.sv
module bus_addr_decoder_chk (
  input logic [6:0] addr_hi,
  input logic       rd_wr,
  input logic       as_n,
  input logic       uds_n,
  input logic       lds_n,
  input logic       prom_oe_u_n, prom_oe_l_n,
  input logic       wram_rd_u_n, wram_rd_l_n, wram_wr_u_n, wram_wr_l_n,
  input logic       cart_oe_u_n, cart_oe_l_n, cart_we_u_n, cart_we_l_n,
  input logic       srom_oe_u_n, srom_oe_l_n,
  input logic       bram_oe_u_n, bram_oe_l_n, bram_we_u_n, bram_we_l_n,
  input logic       vid_rd_n, vid_wr_n, pal_sel_n,
  input logic       card_sel_n, card_rd_n, card_wr_n
);

  logic [10:0] upper_n, lower_n;
  logic [7:0]  region_on;
  logic        all_idle, unmapped, rom_area;

  assign upper_n = {prom_oe_u_n, wram_rd_u_n, wram_wr_u_n, cart_oe_u_n, cart_we_u_n,
                    srom_oe_u_n, bram_oe_u_n, bram_we_u_n, 3'b111};
  assign lower_n = {prom_oe_l_n, wram_rd_l_n, wram_wr_l_n, cart_oe_l_n, cart_we_l_n,
                    srom_oe_l_n, bram_oe_l_n, bram_we_l_n, 3'b111};
  assign region_on = {
    !(prom_oe_u_n && prom_oe_l_n),
    !(wram_rd_u_n && wram_rd_l_n && wram_wr_u_n && wram_wr_l_n),
    !(cart_oe_u_n && cart_oe_l_n && cart_we_u_n && cart_we_l_n),
    !(srom_oe_u_n && srom_oe_l_n),
    !(bram_oe_u_n && bram_oe_l_n && bram_we_u_n && bram_we_l_n),
    !(vid_rd_n && vid_wr_n),
    !pal_sel_n,
    !(card_sel_n && card_rd_n && card_wr_n)};
  assign all_idle = (region_on == 8'h00);
  assign unmapped = (addr_hi >= 7'h18 && addr_hi <= 7'h1D) || addr_hi == 7'h1F || addr_hi >= 7'h70;
  assign rom_area = addr_hi[6:3] == 4'b0000 || addr_hi[6:3] == 4'b1100;

  always_comb begin
    if (!$isunknown({addr_hi, rd_wr, as_n, uds_n, lds_n})) begin
      AST_IDLE_WITHOUT_AS: assert (!as_n || all_idle) else $error("strobe without AS"); // R10
      AST_UPPER_LANE_GATED: assert (!uds_n || &upper_n) else $error("upper lane without UDS"); // R9
      AST_LOWER_LANE_GATED: assert (!lds_n || &lower_n) else $error("lower lane without LDS"); // R9
      AST_ROM_WRITE_SILENT: assert (!(rom_area && !rd_wr) || all_idle) else $error("ROM write strobe"); // R11
      AST_SROM_DECODE: assert ((srom_oe_u_n && srom_oe_l_n) || (addr_hi[6:3] == 4'b1100 && rd_wr)) else $error("bad system ROM enable"); // R4
      AST_UNMAPPED_IDLE: assert (!unmapped || all_idle) else $error("strobe in hole"); // R12
      AST_ONE_REGION: assert ($countones(region_on) <= 1) else $error("two regions selected"); // R12
    end
  end

endmodule

bind bus_addr_decoder bus_addr_decoder_chk u_chk (.*);

// File: tb/bus_addr_decoder_test.sv
module bus_addr_decoder_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [6:0] addr_hi = '0;
  logic rd_wr = 1'b1, as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic prom_oe_u_n, prom_oe_l_n, wram_rd_u_n, wram_rd_l_n, wram_wr_u_n, wram_wr_l_n;
  logic cart_oe_u_n, cart_oe_l_n, cart_we_u_n, cart_we_l_n, srom_oe_u_n, srom_oe_l_n;
  logic bram_oe_u_n, bram_oe_l_n, bram_we_u_n, bram_we_l_n, vid_rd_n, vid_wr_n;
  logic pal_sel_n, card_sel_n, card_rd_n, card_wr_n;

  bus_addr_decoder uut (.*);

  int checks = 0, fails = 0;
  logic done = 1'b0;

  logic [21:0] act;
  assign act = {prom_oe_u_n, prom_oe_l_n, wram_rd_u_n, wram_rd_l_n, wram_wr_u_n, wram_wr_l_n,
                cart_oe_u_n, cart_oe_l_n, cart_we_u_n, cart_we_l_n, srom_oe_u_n, srom_oe_l_n,
                bram_oe_u_n, bram_oe_l_n, bram_we_u_n, bram_we_l_n, vid_rd_n, vid_wr_n,
                pal_sel_n, card_sel_n, card_rd_n, card_wr_n};

  function automatic string req_of(int b);
    if (b >= 20) return "R1";
    if (b >= 16) return "R2";
    if (b >= 12) return "R3";
    if (b >= 10) return "R4";
    if (b >= 6)  return "R5";
    if (b >= 4)  return "R6";
    if (b == 3)  return "R7";
    return "R8";
  endfunction

  function automatic logic [21:0] expect_of(logic [6:0] ah, logic r, logic as, logic ud, logic ld);
    int a = int'(ah) << 17;
    logic u = !as && !ud, l = !as && !ld, w = u || l, wr = !r;
    logic [21:0] e = '1;
    if (a < 'h100000) begin e[21] = !(r && u); e[20] = !(r && l); end
    else if (a < 'h200000) begin
      e[19] = !(r && u); e[18] = !(r && l); e[17] = !(wr && u); e[16] = !(wr && l);
    end else if (a < 'h300000) begin
      e[15] = !(r && u); e[14] = !(r && l); e[13] = !(wr && u); e[12] = !(wr && l);
    end else if (a >= 'h3C0000 && a < 'h3E0000) begin
      e[5] = !(r && w); e[4] = !(wr && w);
    end else if (a >= 'h400000 && a < 'h800000) e[3] = !w;
    else if (a >= 'h800000 && a < 'hC00000) begin
      e[2] = !w; e[1] = !(r && w); e[0] = !(wr && w);
    end else if (a >= 'hC00000 && a < 'hD00000) begin e[11] = !(r && u); e[10] = !(r && l); end
    else if (a >= 'hD00000 && a < 'hE00000) begin
      e[9] = !(r && u); e[8] = !(r && l); e[7] = !(wr && u); e[6] = !(wr && l);
    end
    return e;
  endfunction

  task automatic compare(string tag);
    logic [21:0] e = expect_of(addr_hi, rd_wr, as_n, uds_n, lds_n);
    int a = int'(addr_hi) << 17;
    bit hole = (a >= 'h300000 && a < 'h3C0000) || (a >= 'h3E0000 && a < 'h400000) || a >= 'hE00000;
    bit romw = !rd_wr && (a < 'h100000 || (a >= 'hC00000 && a < 'hD00000));
    for (int b = 0; b < 22; b++) begin
      string rq = tag != "" ? tag : as_n ? "R10" : hole ? "R12" : romw ? "R11" : req_of(b);
      checks++;
      if (act[b] !== e[b]) begin
        fails++;
        $display("FAIL %s addr=%06h rw=%b as=%b uds=%b lds=%b out bit %0d: got %b expected %b",
                 rq, a, rd_wr, as_n, uds_n, lds_n, b, act[b], e[b]);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    compare("R10"); // idle state with AS high
    for (int ah = 0; ah < 128; ah++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 8; s++) begin
          @(posedge clk);
          addr_hi <= 7'(ah); rd_wr <= r[0];
          as_n <= s[2]; uds_n <= s[1]; lds_n <= s[0];
          @(negedge clk);
          compare(""); // R1..R8 per region, R9 lanes, R10 AS, R11 ROM writes, R12 holes
        end
    // R10: strobes drop in the same cycle AS rises, during a work RAM word write
    @(posedge clk); addr_hi <= 7'h08; rd_wr <= 1'b0; as_n <= 1'b0; uds_n <= 1'b0; lds_n <= 1'b0;
    @(negedge clk); compare("R2");
    as_n <= 1'b1; #1; compare("R10");
    done = 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
  end

  initial begin
    wait (done || $time > 499000);
    #10;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule